// File: doc/BRIEF.md
# Half-Word Shifter with Status Flags

This block shifts one 16-bit half of a 32-bit source operand by a constant amount from 0 to 15 and writes the result into one half of a 32-bit destination register. The other half of the destination stays as it was. Three shift kinds are available: a left shift that fills with zeros, a right shift that fills with zeros, and a right shift that fills with copies of the sign bit. The source half and the destination half are chosen independently, so a high half can land in the low half and the reverse.

Each issued operation also loads a five-bit status register. The zero and negative flags come from the 16-bit result. The carry flag and both overflow flags are always cleared. The destination register and the status register load on the same rising clock edge, and only when the operation-valid strobe is high. When no operation is issued, both keep their values.

Top module: `hw_shift_unit`

## Requirements
- R1: With the shift kind code 2'b00 (left), the selected source half is shifted left by the amount and filled with zeros; 0x0001 by 4 gives 0x0010, and by 15 gives 0x8000.
- R2: With code 2'b01 (logical right), the half is shifted right and filled with zeros; 0x8000 by 4 gives 0x0800.
- R3: With code 2'b10 (arithmetic right), the half is shifted right and filled with copies of its bit 15; 0x8000 by 4 gives 0xF800.
- R4: An amount of 0 passes the source half through unchanged. Only amount bits [3:0] are used.
- R5: The source half select (0 = bits [15:0], 1 = bits [31:16]) and the destination half select (same encoding) are independent.
- R6: The destination half that is not selected keeps its previous contents.
- R7: The zero flag (flags bit 0) is 1 exactly when the 16-bit result is zero.
- R8: The negative flag (flags bit 1) equals bit 15 of the result, including when a left shift moves a 1 into bit 15.
- R9: The carry flag (bit 2) and the overflow flags (bits 3 and 4) are 0 after every operation.
- R10: The destination and the flags update one clock edge after op_valid is sampled high, and hold their values while it is low.
- R11: A synchronous active-high reset clears the destination and all flags.
- R12: Shift kind code 2'b11 behaves as a left shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue one shift this cycle |
| src_word | input | 32 | Source operand |
| src_hi | input | 1 | 1 selects the source high half |
| dst_hi | input | 1 | 1 selects the destination high half |
| shift_kind | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 left |
| shift_amt | input | 5 | Shift amount; only bits [3:0] are used |
| dst_word | output | 32 | Destination register |
| flags | output | 5 | {ovf1, ovf0, carry, negative, zero} |

## Verification
The assertions assume that every control input is a known 0 or 1 during any cycle with op_valid high, and that reset is held for at least one edge before the first operation. Their one-cycle $past checks also assume the inputs are steady at the sampling edge. The bench drives every input on the falling edge and keeps it until after the next rising edge. It also drives shift_amt values with bit 4 set to show that this bit is ignored, which the design permits.

// File: rtl/hw_shift_pkg.sv
package hw_shift_pkg;
   typedef enum logic [1:0] {
      SK_LSL  = 2'b00,
      SK_LSR  = 2'b01,
      SK_ASR  = 2'b10,
      SK_RSVD = 2'b11
   } shift_kind_e;

   localparam int FLAG_ZERO = 0;
   localparam int FLAG_NEG  = 1;
   localparam int FLAG_CARRY = 2;
   localparam int FLAG_OVF0 = 3;
   localparam int FLAG_OVF1 = 4;
   localparam int FLAG_W    = 5;
endpackage

// File: rtl/hw_half_shifter.sv
module hw_half_shifter #(
   parameter int HALF_W = 16,
   parameter int AMT_W  = 4
) (
   input  logic [HALF_W-1:0] din,
   input  logic [1:0]        kind,
   input  logic [AMT_W-1:0]  amt,
   output logic [HALF_W-1:0] dout
);
   import hw_shift_pkg::*;

   initial begin
      if ((1 << AMT_W) > HALF_W)
         $error("hw_half_shifter: AMT_W too wide for HALF_W");
   end

   // Logarithmic barrel: one stage per amount bit.
   logic [HALF_W-1:0] stage [0:AMT_W];
   logic              go_left;
   logic              fill;

   always_comb begin
      go_left = (kind == SK_LSL) || (kind == SK_RSVD);
      fill    = (kind == SK_ASR) ? din[HALF_W-1] : 1'b0;
   end

   assign stage[0] = din;

   for (genvar s = 0; s < AMT_W; s++) begin : g_stage
      localparam int SH = 1 << s;
      logic [HALF_W-1:0] moved;
      always_comb begin
         if (go_left) moved = {stage[s][HALF_W-1-SH:0], {SH{1'b0}}};
         else         moved = {{SH{fill}}, stage[s][HALF_W-1:SH]};
      end
      assign stage[s+1] = amt[s] ? moved : stage[s];
   end

   assign dout = stage[AMT_W];
endmodule

// File: rtl/hw_shift_flags.sv
module hw_shift_flags #(
   parameter int HALF_W = 16,
   parameter int FLAG_W = 5
) (
   input  logic [HALF_W-1:0] res,
   output logic [FLAG_W-1:0] nxt_flags
);
   import hw_shift_pkg::*;

   initial begin
      if (FLAG_W != hw_shift_pkg::FLAG_W)
         $error("hw_shift_flags: FLAG_W mismatch");
   end

   always_comb begin
      nxt_flags             = '0;
      nxt_flags[FLAG_ZERO]  = (res == '0);
      nxt_flags[FLAG_NEG]   = res[HALF_W-1];
   end
endmodule

// File: rtl/hw_shift_unit.sv
module hw_shift_unit #(
   parameter int WORD_W = 32,
   parameter int AMT_IN_W = 5
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      op_valid,
   input  logic [WORD_W-1:0]         src_word,
   input  logic                      src_hi,
   input  logic                      dst_hi,
   input  logic [1:0]                shift_kind,
   input  logic [AMT_IN_W-1:0]       shift_amt,
   output logic [WORD_W-1:0]         dst_word,
   output logic [hw_shift_pkg::FLAG_W-1:0] flags
);
   import hw_shift_pkg::*;

   localparam int HALF_W = WORD_W / 2;
   localparam int AMT_W  = $clog2(HALF_W);

   initial begin
      if (WORD_W % 2 != 0) $error("hw_shift_unit: WORD_W must be even");
      if (AMT_IN_W < AMT_W) $error("hw_shift_unit: shift_amt too narrow");
   end

   logic [HALF_W-1:0] src_half;
   logic [HALF_W-1:0] shifted;
   logic [FLAG_W-1:0] nxt_flags;

   assign src_half = src_hi ? src_word[WORD_W-1:HALF_W] : src_word[HALF_W-1:0];

   hw_half_shifter #(.HALF_W(HALF_W), .AMT_W(AMT_W)) u_shifter (
      .din  (src_half),
      .kind (shift_kind),
      .amt  (shift_amt[AMT_W-1:0]),
      .dout (shifted)
   );

   hw_shift_flags #(.HALF_W(HALF_W), .FLAG_W(FLAG_W)) u_flags (
      .res       (shifted),
      .nxt_flags (nxt_flags)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         dst_word <= '0;
         flags    <= '0;
      end else if (op_valid) begin
         if (dst_hi) dst_word[WORD_W-1:HALF_W] <= shifted;
         else        dst_word[HALF_W-1:0]      <= shifted;
         flags <= nxt_flags;
      end
   end

   a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
      flags[FLAG_W-1:FLAG_CARRY] == '0);

   a_r6_other_half_kept: assert property (@(posedge clk) disable iff (rst)
      op_valid && !dst_hi |=> dst_word[WORD_W-1:HALF_W] == $past(dst_word[WORD_W-1:HALF_W]));

   a_r6_low_half_kept: assert property (@(posedge clk) disable iff (rst)
      op_valid && dst_hi |=> dst_word[HALF_W-1:0] == $past(dst_word[HALF_W-1:0]));

   a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !op_valid |=> $stable(dst_word) && $stable(flags));

   a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
      op_valid && dst_hi |=> flags[FLAG_ZERO] == (dst_word[WORD_W-1:HALF_W] == '0));

   a_r8_neg_flag: assert property (@(posedge clk) disable iff (rst)
      op_valid && !dst_hi |=> flags[FLAG_NEG] == dst_word[HALF_W-1]);

   a_r4_pass: assert property (@(posedge clk) disable iff (rst)
      op_valid && shift_amt[AMT_W-1:0] == '0 && !src_hi && !dst_hi
      |=> dst_word[HALF_W-1:0] == $past(src_word[HALF_W-1:0]));
endmodule

// File: tb/hw_shift_unit_tb.sv
module hw_shift_unit_tb;
   logic        clk = 0;
   logic        rst;
   logic        op_valid;
   logic [31:0] src_word;
   logic        src_hi, dst_hi;
   logic [1:0]  shift_kind;
   logic [4:0]  shift_amt;
   logic [31:0] dst_word;
   logic [4:0]  flags;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2 clk = ~clk;

   hw_shift_unit u_dut (.*);

   task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // flags: {ovf1,ovf0,carry,neg,zero}
   task automatic run_op(logic sh, logic dh, logic [1:0] k, logic [4:0] a, logic [31:0] s);
      @(negedge clk);
      op_valid = 1; src_word = s; src_hi = sh; dst_hi = dh; shift_kind = k; shift_amt = a;
      @(negedge clk);
      op_valid = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0;
   endtask

   task automatic t_reset();
      do_reset();
      chk32("R11 dst", dst_word, 32'h0);
      chk32("R11 flags", {27'd0, flags}, 32'h0);
   endtask

   task automatic t_left();
      do_reset();
      run_op(0, 0, 2'b00, 5'd4, 32'h0001_0001);
      chk32("R1 lsl4", dst_word, 32'h0000_0010);
      chk32("R7 R9 flags lsl4", {27'd0, flags}, 32'h0);
      do_reset();
      run_op(0, 0, 2'b00, 5'd15, 32'h0000_0001);
      chk32("R1 lsl15", dst_word, 32'h0000_8000);
      chk32("R8 R9 neg via lsl", {27'd0, flags}, 32'h2);
   endtask

   task automatic t_right();
      do_reset();
      run_op(0, 0, 2'b10, 5'd4, 32'h0001_8000);
      chk32("R3 asr4", dst_word, 32'h0000_F800);
      chk32("R8 asr flags", {27'd0, flags}, 32'h2);
      do_reset();
      run_op(1, 0, 2'b01, 5'd4, 32'h8000_0001);
      chk32("R2 R5 lsr4 hi->lo", dst_word, 32'h0000_0800);
      chk32("R2 flags", {27'd0, flags}, 32'h0);
      do_reset();
      run_op(1, 1, 2'b10, 5'd4, 32'h8000_0001);
      chk32("R3 R5 asr hi->hi", dst_word, 32'hF800_0000);
      do_reset();
      run_op(1, 0, 2'b10, 5'd15, 32'h7FFF_0000);
      chk32("R3 asr positive", dst_word, 32'h0000_0000);
      chk32("R7 zero after asr", {27'd0, flags}, 32'h1);
   endtask

   task automatic t_cross_and_keep();
      do_reset();
      run_op(0, 1, 2'b00, 5'd4, 32'h0001_0001);
      chk32("R5 lo->hi", dst_word, 32'h0010_0000);
      run_op(0, 0, 2'b00, 5'd0, 32'h0000_1234);
      chk32("R6 R4 hi kept", dst_word, 32'h0010_1234);
      run_op(0, 1, 2'b01, 5'd0, 32'h0000_0000);
      chk32("R6 R7 lo kept", dst_word, 32'h0000_1234);
      chk32("R7 zero flag", {27'd0, flags}, 32'h1);
   endtask

   task automatic t_amt_and_code();
      do_reset();
      run_op(0, 0, 2'b00, 5'd20, 32'h0000_0001);
      chk32("R4 amt bit4 ignored", dst_word, 32'h0000_0010);
      run_op(0, 0, 2'b11, 5'd3, 32'h0000_0101);
      chk32("R12 code11 left", dst_word, 32'h0000_0808);
      run_op(0, 0, 2'b00, 5'd0, 32'h0000_8000);
      chk32("R4 pass", dst_word, 32'h0000_8000);
      chk32("R8 pass neg", {27'd0, flags}, 32'h2);
   endtask

   task automatic t_hold();
      do_reset();
      run_op(0, 0, 2'b00, 5'd1, 32'h0000_C000);
      chk32("R1 carry-out case", dst_word, 32'h0000_8000);
      chk32("R9 no carry on sign change", {27'd0, flags}, 32'h2);
      @(negedge clk);
      src_word = 32'hFFFF_FFFF; shift_kind = 2'b10; shift_amt = 5'd0; src_hi = 1;
      @(negedge clk);
      @(negedge clk);
      chk32("R10 hold dst", dst_word, 32'h0000_8000);
      chk32("R10 hold flags", {27'd0, flags}, 32'h2);
   endtask

   initial begin
      rst = 1; op_valid = 0; src_word = 0; src_hi = 0; dst_hi = 0;
      shift_kind = 0; shift_amt = 0;
      t_reset();
      t_left();
      t_right();
      t_cross_and_keep();
      t_amt_and_code();
      t_hold();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule